// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out the instruction that configures vector lengths for a vector engine that runs over the ordinary scalar register file. It holds two architectural registers. The maximum vector length (MVL) bounds how much of the register file one vector operation may span. The vector length (VL) is the element count that later vector instructions will use. The surrounding pipeline presents a decoded 32-bit instruction word with a valid strobe, the RA and RT register indices, the RA operand and the count register (CTR). One cycle later the unit shows its updated MVL and VL, together with an optional RT writeback value and its write enable.

VL always takes the requested length, limited only by MVL. No opcode bit selects the source of that length. The source follows from whether the RA and RT indices are zero: a nonzero RA supplies the RA operand, a zero RA with a nonzero RT supplies CTR, and both zero supply the immediate. Immediates carry a bias of one, so the immediate path can never produce a length of zero. A form with all mode bits clear is a read-only query that returns VL and changes nothing. Element stepping, condition-register updates and register file storage belong to other blocks.

Top module: `vlcfg_unit`

## Requirements
- R1: After a synchronous active-low reset, MVL and VL both read 1 and `rt_we` is 0.
- R2: The instruction is acted on only when its sub-opcode field `instr[5:1]` equals 5'b11011. Any other value leaves MVL and VL unchanged and raises no writeback.
- R3: When the MVL-set bit `instr[8]` is 1, MVL becomes SVi+1, where SVi is `instr[15:9]`. Results above 127 saturate to 127, so MVL is never 0.
- R4: When the VL-set bit `instr[7]` is 1 and both `ra_idx` and `rt_idx` are 0, VL becomes MIN(MVL, SVi+1) and no writeback occurs.
- R5: When the VL-set bit is 1, `ra_idx` is 0 and `rt_idx` is nonzero, VL becomes MIN(MVL, CTR). `rt_data` carries the same value with `rt_we` = 1.
- R6: When the VL-set bit is 1 and `ra_idx` is nonzero, VL becomes MIN(MVL, `ra_val`) as an unsigned 64-bit comparison, and CTR is ignored. RT is written with that value exactly when `rt_idx` is nonzero.
- R7: When both set bits are 1, the MIN uses the newly loaded MVL, not the old one.
- R8: With `instr[8:6]` all 0 (the query form), `rt_data` returns the current VL with `rt_we` = 1 when `rt_idx` is nonzero. MVL and VL stay unchanged.
- R9: When only the MVL-set bit is 1 and the new MVL is below VL, VL is lowered to the new MVL. Otherwise VL is kept. VL never exceeds MVL.
- R10: Effects appear after the clock edge on which `instr_valid` is 1. `rt_we` lasts one cycle per instruction, and with `instr_valid` at 0 nothing changes.
- R11: With the stepping bit `instr[6]` set and both set bits clear, MVL and VL are unchanged and no writeback occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Decoded instruction word, LSB-numbered |
| ra_idx | input | 5 | RA register index |
| rt_idx | input | 5 | RT register index |
| ra_val | input | 64 | Value of RA |
| ctr_val | input | 64 | Value of CTR |
| mvl | output | 7 | Current maximum vector length |
| vl | output | 7 | Current vector length |
| rt_we | output | 1 | RT writeback enable |
| rt_data | output | 64 | RT writeback value |

## Verification
Several properties are checked by assertions on every cycle:
- VL never exceeds MVL, and MVL is never zero.
- Any writeback value equals the VL the unit now holds.
- A rejected sub-opcode, a query, or an idle cycle leaves both lengths stable.
- A length taken from RA never exceeds that operand.

Only the directed scenarios can show the exact values:
- the immediate bias and its saturation at 127;
- the choice among immediate, RA and CTR sources;
- use of the new MVL when both set bits are present;
- the clamping of VL when MVL shrinks;
- the one-cycle delay from issue to result.

// File: rtl/vlcfg_pkg.sv
// Shared types and constants for the vector length configuration unit.
// Assumes LSB bit numbering of the 32-bit instruction word.
package vlcfg_pkg;

    localparam int          SVI_W    = 7;
    localparam int          IDX_W    = 5;
    localparam logic [4:0]  XO_SETVL = 5'b11011;

    // Fields of the word that steer this unit
    typedef struct packed {
        logic [SVI_W-1:0] svi;
        logic             set_mvl;
        logic             set_vl;
        logic             step;
    } vlcfg_fields_t;

    // Operation class derived from the mode bits
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_QUERY  = 2'd1,
        OP_CONFIG = 2'd2,
        OP_STEP   = 2'd3
    } vlcfg_op_e;

endpackage

// File: rtl/vlcfg_decode.sv
// Field extraction and operation classification.
// Assumes the caller already matched the primary opcode; only the
// sub-opcode is checked here. Purely combinational.
module vlcfg_decode
    import vlcfg_pkg::*;
(
    input  logic          valid_i,
    input  logic [31:0]   instr_i,
    output vlcfg_fields_t fields_o,
    output vlcfg_op_e     op_o
);
    localparam int POS_XO_LO  = 1;
    localparam int POS_STEP   = 6;
    localparam int POS_SETVL  = 7;
    localparam int POS_SETMVL = 8;
    localparam int POS_SVI_LO = 9;

    logic xo_hit;
    logic unused_word;

    // Sub-opcode match
    assign xo_hit = (instr_i[POS_XO_LO +: 5] == XO_SETVL);

    // Bits handled by other stages (opcode, register fields, record bit)
    assign unused_word = ^{instr_i[31:16], instr_i[0]};

    // Field extraction
    assign fields_o.svi     = instr_i[POS_SVI_LO +: SVI_W];
    assign fields_o.set_mvl = instr_i[POS_SETMVL];
    assign fields_o.set_vl  = instr_i[POS_SETVL];
    assign fields_o.step    = instr_i[POS_STEP];

    // Classify the operation
    always_comb begin
        if (!(valid_i && xo_hit))
            op_o = OP_IDLE;
        else if (fields_o.set_mvl || fields_o.set_vl)
            op_o = OP_CONFIG;
        else if (fields_o.step)
            op_o = OP_STEP;
        else
            op_o = OP_QUERY;
    end

endmodule

// File: rtl/vlcfg_lensel.sv
// Next-state computation: biased immediate, source selection, MIN
// against MVL, and RT writeback value. Combinational.
// Assumes XLEN > LEN_W.
module vlcfg_lensel
    import vlcfg_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LEN_W = 7
) (
    input  vlcfg_fields_t    fields_i,
    input  vlcfg_op_e        op_i,
    input  logic             ra_zero_i,
    input  logic             rt_zero_i,
    input  logic [XLEN-1:0]  ra_val_i,
    input  logic [XLEN-1:0]  ctr_val_i,
    input  logic [LEN_W-1:0] cur_mvl_i,
    input  logic [LEN_W-1:0] cur_vl_i,
    output logic [LEN_W-1:0] nxt_mvl_o,
    output logic [LEN_W-1:0] nxt_vl_o,
    output logic             wb_en_o,
    output logic [XLEN-1:0]  wb_data_o
);
    localparam int               SUM_W   = SVI_W + 1;
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    logic [SUM_W-1:0] imm_sum;
    logic [LEN_W-1:0] imm_len;
    logic [LEN_W-1:0] mvl_eff;
    logic [XLEN-1:0]  cap_ext;
    logic [XLEN-1:0]  src;
    logic [LEN_W-1:0] capped;

    // Biased immediate
    assign imm_sum = {1'b0, fields_i.svi} + SUM_W'(1);

    // Fit the biased immediate into the length register
    generate
        if (LEN_W >= SUM_W) begin : g_imm_fits
            assign imm_len = LEN_W'(imm_sum);
        end else begin : g_imm_sat
            localparam logic [SUM_W-1:0] MAX_EXT = {{(SUM_W-LEN_W){1'b0}}, LEN_MAX};
            assign imm_len = (imm_sum > MAX_EXT) ? LEN_MAX : imm_sum[LEN_W-1:0];
        end
    endgenerate

    // New MVL takes effect before the MIN
    assign mvl_eff = fields_i.set_mvl ? imm_len : cur_mvl_i;
    assign cap_ext = {{(XLEN-LEN_W){1'b0}}, mvl_eff};

    // Source for VL picked by the register indices
    always_comb begin
        if (!ra_zero_i)
            src = ra_val_i;
        else if (!rt_zero_i)
            src = ctr_val_i;
        else
            src = {{(XLEN-LEN_W){1'b0}}, imm_len};
    end

    // Unsigned MIN against MVL
    assign capped = (src < cap_ext) ? src[LEN_W-1:0] : mvl_eff;

    // Next lengths and writeback per operation class
    always_comb begin
        nxt_mvl_o = cur_mvl_i;
        nxt_vl_o  = cur_vl_i;
        wb_en_o   = 1'b0;
        wb_data_o = '0;
        case (op_i)
            OP_CONFIG: begin
                nxt_mvl_o = mvl_eff;
                if (fields_i.set_vl) begin
                    nxt_vl_o  = capped;
                    wb_en_o   = !rt_zero_i;
                    wb_data_o = {{(XLEN-LEN_W){1'b0}}, capped};
                end else if (cur_vl_i > mvl_eff) begin
                    nxt_vl_o = mvl_eff;
                end
            end
            OP_QUERY: begin
                wb_en_o   = !rt_zero_i;
                wb_data_o = {{(XLEN-LEN_W){1'b0}}, cur_vl_i};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vlcfg_state.sv
// Architectural MVL and VL registers plus the registered RT writeback.
// Assumes next values already respect VL <= MVL.
module vlcfg_state #(
    parameter int XLEN  = 64,
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] nxt_mvl_i,
    input  logic [LEN_W-1:0] nxt_vl_i,
    input  logic             wb_en_i,
    input  logic [XLEN-1:0]  wb_data_i,
    output logic [LEN_W-1:0] mvl_o,
    output logic [LEN_W-1:0] vl_o,
    output logic             rt_we_o,
    output logic [XLEN-1:0]  rt_data_o
);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    // Length registers, scalar identity at reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mvl_o <= LEN_ONE;
            vl_o  <= LEN_ONE;
        end else if (load_i) begin
            mvl_o <= nxt_mvl_i;
            vl_o  <= nxt_vl_i;
        end
    end

    // Writeback pulse and data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_we_o   <= 1'b0;
            rt_data_o <= '0;
        end else begin
            rt_we_o   <= wb_en_i;
            rt_data_o <= wb_data_i;
        end
    end

    assert_vl_le_mvl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vl_o <= mvl_o);

    assert_mvl_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mvl_o != '0);

    assert_wb_matches_vl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rt_we_o |-> (rt_data_o == {{(XLEN-LEN_W){1'b0}}, vl_o}));

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(mvl_o) && $stable(vl_o)));

endmodule

// File: rtl/vlcfg_unit.sv
// Vector length configuration unit top: decode, next-state, registers.
// One instruction per cycle; results visible after the issuing edge.
module vlcfg_unit
    import vlcfg_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [31:0]      instr,
    input  logic [IDX_W-1:0] ra_idx,
    input  logic [IDX_W-1:0] rt_idx,
    input  logic [XLEN-1:0]  ra_val,
    input  logic [XLEN-1:0]  ctr_val,
    output logic [LEN_W-1:0] mvl,
    output logic [LEN_W-1:0] vl,
    output logic             rt_we,
    output logic [XLEN-1:0]  rt_data
);
    vlcfg_fields_t    fields;
    vlcfg_op_e        op;
    logic [LEN_W-1:0] nxt_mvl;
    logic [LEN_W-1:0] nxt_vl;
    logic             wb_en;
    logic [XLEN-1:0]  wb_data;
    logic             ra_zero;
    logic             rt_zero;

    // Index tests that pick the VL source
    assign ra_zero = (ra_idx == '0);
    assign rt_zero = (rt_idx == '0);

    vlcfg_decode u_decode (
        .valid_i  (instr_valid),
        .instr_i  (instr),
        .fields_o (fields),
        .op_o     (op)
    );

    vlcfg_lensel #(.XLEN(XLEN), .LEN_W(LEN_W)) u_lensel (
        .fields_i  (fields),
        .op_i      (op),
        .ra_zero_i (ra_zero),
        .rt_zero_i (rt_zero),
        .ra_val_i  (ra_val),
        .ctr_val_i (ctr_val),
        .cur_mvl_i (mvl),
        .cur_vl_i  (vl),
        .nxt_mvl_o (nxt_mvl),
        .nxt_vl_o  (nxt_vl),
        .wb_en_o   (wb_en),
        .wb_data_o (wb_data)
    );

    vlcfg_state #(.XLEN(XLEN), .LEN_W(LEN_W)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (op == OP_CONFIG),
        .nxt_mvl_i (nxt_mvl),
        .nxt_vl_i  (nxt_vl),
        .wb_en_i   (wb_en),
        .wb_data_i (wb_data),
        .mvl_o     (mvl),
        .vl_o      (vl),
        .rt_we_o   (rt_we),
        .rt_data_o (rt_data)
    );

    assert_bad_xo_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[5:1] != XO_SETVL)
        |=> ($stable(mvl) && $stable(vl) && !rt_we));

    assert_query_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[5:1] == XO_SETVL && instr[8:6] == 3'b000)
        |=> ($stable(mvl) && $stable(vl)));

    assert_ra_bounds_vl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[5:1] == XO_SETVL && instr[7] && ra_idx != '0)
        |=> ({{(XLEN-LEN_W){1'b0}}, vl} <= $past(ra_val)));

    assert_step_no_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[5:1] == XO_SETVL && instr[8:6] == 3'b001)
        |=> ($stable(mvl) && $stable(vl) && !rt_we));

endmodule

// File: tb/sim_vlcfg_unit.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_vlcfg_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] XO_OK  = 5'b11011;
    localparam logic [4:0] XO_BAD = 5'b11010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [4:0]  ra_idx = '0;
    logic [4:0]  rt_idx = '0;
    logic [63:0] ra_val = '0;
    logic [63:0] ctr_val = '0;
    logic [6:0]  mvl;
    logic [6:0]  vl;
    logic        rt_we;
    logic [63:0] rt_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vlcfg_unit u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .ra_idx(ra_idx), .rt_idx(rt_idx), .ra_val(ra_val), .ctr_val(ctr_val),
        .mvl(mvl), .vl(vl), .rt_we(rt_we), .rt_data(rt_data)
    );

    function automatic logic [31:0] mk(input logic [6:0] svi, input logic ms,
                                       input logic vs, input logic vf, input logic [4:0] xo);
        return {6'd22, 5'd17, 5'd9, svi, ms, vs, vf, xo, 1'b0};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one instruction for one cycle; outputs are settled on return
    task automatic issue(input logic [6:0] svi, input logic ms, input logic vs,
                         input logic vf, input logic [4:0] xo, input logic [4:0] ra,
                         input logic [4:0] rt, input logic [63:0] rav, input logic [63:0] ctr);
        @(negedge clk);
        instr = mk(svi, ms, vs, vf, xo);
        ra_idx = ra; rt_idx = rt; ra_val = rav; ctr_val = ctr;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic expect_state(input string req, input int m, input int v, input logic we,
                                input logic [63:0] d);
        check(req, 64'(mvl), 64'(m));
        check(req, 64'(vl), 64'(v));
        check(req, 64'(rt_we), 64'(we));
        if (we) check(req, rt_data, d);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_state("R1", 1, 1, 1'b0, 0);
    endtask

    task automatic t_mvl_imm;
        issue(7'd15, 1, 0, 0, XO_OK, 0, 0, 0, 0);  expect_state("R3", 16, 1, 0, 0);
        issue(7'd0, 1, 0, 0, XO_OK, 0, 0, 0, 0);   expect_state("R3", 1, 1, 0, 0);
        issue(7'd127, 1, 0, 0, XO_OK, 0, 0, 0, 0); expect_state("R3", 127, 1, 0, 0);
        issue(7'd63, 1, 0, 0, XO_OK, 0, 0, 0, 0);  expect_state("R3", 64, 1, 0, 0);
    endtask

    task automatic t_vl_imm;
        issue(7'd9, 0, 1, 0, XO_OK, 0, 0, 0, 77);  expect_state("R4", 64, 10, 0, 0);
        issue(7'd99, 0, 1, 0, XO_OK, 0, 0, 0, 0);  expect_state("R4", 64, 64, 0, 0);
    endtask

    task automatic t_vl_ctr;
        issue(7'd0, 0, 1, 0, XO_OK, 0, 5, 0, 40);   expect_state("R5", 64, 40, 1, 40);
        issue(7'd0, 0, 1, 0, XO_OK, 0, 5, 0, 1000); expect_state("R5", 64, 64, 1, 64);
        issue(7'd3, 0, 1, 0, XO_OK, 0, 5, 0, 0);    expect_state("R5", 64, 0, 1, 0);
    endtask

    task automatic t_vl_ra;
        issue(7'd0, 0, 1, 0, XO_OK, 3, 0, 7, 5);  expect_state("R6", 64, 7, 0, 0);
        issue(7'd0, 0, 1, 0, XO_OK, 3, 9, 64'hFFFF_FFFF_FFFF_FF00, 5);
        expect_state("R6", 64, 64, 1, 64);
    endtask

    task automatic t_both;
        issue(7'd7, 1, 1, 0, XO_OK, 0, 0, 0, 0);    expect_state("R7", 8, 8, 0, 0);
        issue(7'd31, 1, 1, 0, XO_OK, 0, 2, 0, 3);   expect_state("R7", 32, 3, 1, 3);
        issue(7'd3, 1, 1, 0, XO_OK, 1, 0, 100, 0);  expect_state("R7", 4, 4, 0, 0);
    endtask

    task automatic t_clamp;
        issue(7'd31, 1, 0, 0, XO_OK, 0, 0, 0, 0);   expect_state("R9", 32, 4, 0, 0);
        issue(7'd0, 0, 1, 0, XO_OK, 0, 1, 0, 50);   expect_state("R9", 32, 32, 1, 32);
        issue(7'd4, 1, 0, 0, XO_OK, 0, 6, 0, 0);    expect_state("R9", 5, 5, 0, 0);
    endtask

    task automatic t_query;
        issue(7'd40, 0, 0, 0, XO_OK, 2, 6, 90, 90); expect_state("R8", 5, 5, 1, 5);
        issue(7'd40, 0, 0, 0, XO_OK, 0, 0, 0, 0);   expect_state("R8", 5, 5, 0, 0);
    endtask

    task automatic t_step;
        issue(7'd3, 0, 0, 1, XO_OK, 0, 7, 0, 9);    expect_state("R11", 5, 5, 0, 0);
    endtask

    task automatic t_ignore;
        issue(7'd20, 1, 1, 0, XO_BAD, 0, 3, 0, 9);  expect_state("R2", 5, 5, 0, 0);
    endtask

    task automatic t_timing;
        // Valid low: a complete set-MVL word must do nothing
        @(negedge clk);
        instr = mk(7'd9, 1, 0, 0, XO_OK);
        instr_valid = 1'b0;
        @(negedge clk);
        expect_state("R10", 5, 5, 0, 0);
        // Before the edge the old VL is still shown
        instr = mk(7'd0, 0, 1, 0, XO_OK);
        ra_idx = 0; rt_idx = 3; ctr_val = 2;
        instr_valid = 1'b1;
        #1;
        check("R10", 64'(vl), 64'd5);
        @(negedge clk);
        instr_valid = 1'b0;
        expect_state("R10", 5, 2, 1, 2);
        @(negedge clk);
        check("R10", 64'(rt_we), 64'd0);
        check("R10", 64'(vl), 64'd2);
    endtask

    initial begin
        t_reset();
        t_mvl_imm();
        t_vl_imm();
        t_vl_ctr();
        t_vl_ra();
        t_both();
        t_clamp();
        t_query();
        t_step();
        t_ignore();
        t_timing();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule